// File: doc/BRIEF.md
# Associative Address Translation Buffer

This block is a fully associative translation buffer. It turns a 32-bit virtual address into a physical address. Every stored entry holds a virtual page number, a physical page number, a page-size code, an address-space tag, a valid flag and a global (shared) flag. A lookup request is registered first. In the next cycle the registered page number and tag are compared against all entries at once. The block then reports exactly one of three outcomes: hit, miss or multiple-match. On a hit it also gives the physical address.

Entries are loaded through a single write port, addressed by slot index. A single invalidate-all input clears every valid flag. Each request carries two per-request mode bits. The first makes the tag compare irrelevant. The second selects the 32-byte aligned form of translation used for burst stores. Physical results above the control boundary are folded up into the top control region.

Top module: `tlb_xlate_top`

## Requirements
- R1: While reset is asserted and after it is released, `rsp_valid_o` is low and every entry is invalid. A lookup made before any entry is written therefore reports a miss.
- R2: A request sampled with `req_valid_i` high at a clock edge raises `rsp_valid_o` for the following cycle. During that cycle exactly one of `rsp_hit_o`, `rsp_miss_o` and `rsp_multi_o` is high. When `rsp_valid_o` is low, all three flags and `rsp_paddr_o` are zero. On a miss or a multiple match, `rsp_paddr_o` is zero.
- R3: An entry takes part in a match only when its valid flag is set and at least one of these holds: its global flag is set, or its stored tag equals `req_asid_i`.
- R4: The page number is `vaddr[31:10]`. Page-size codes are 0 = 1 KB, 1 = 4 KB, 2 = 64 KB and 3 = 1 MB. These codes clear 0, 2, 6 or 10 low bits of the page mask. An entry matches when (stored VPN XOR request VPN) AND mask is zero.
- R5: When two or more entries match, only `rsp_multi_o` is raised and no translation is given.
- R6: On a single match, the physical address before any adjustment is ({ppn,10'b0} AND {mask,10'b0}) OR (vaddr AND NOT {mask,10'b0}).
- R7: For a normal request, a result strictly greater than 0x1C000000 has 0xE0000000 ORed into it. A result equal to 0x1C000000 or below is left unchanged.
- R8: With `req_single_vm_i` set on the request, the tag compare is skipped. Matching then depends on the valid flag and the masked VPN only.
- R9: An invalidate-all cycle clears every valid flag. Lookups sampled afterwards miss.
- R10: When `inv_all_i` and `wr_en_i` are high in the same cycle, the write is discarded and every entry ends invalid.
- R11: A write and a request sampled at the same edge: the lookup sees the new entry. A write made during the cycle in which the response is shown takes effect only for later requests.
- R12: With `req_sq_i` set on the request, bits 4:0 of the hit address are cleared and the remap of R7 is not applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Lookup request strobe |
| req_vaddr_i | input | 32 | Virtual address |
| req_asid_i | input | 8 | Current address-space tag |
| req_single_vm_i | input | 1 | Skip the tag compare for this request |
| req_sq_i | input | 1 | 32-byte aligned translation, no remap |
| inv_all_i | input | 1 | Clear all valid flags |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | 6 | Slot written |
| wr_vld_i | input | 1 | Valid flag to store |
| wr_shr_i | input | 1 | Global flag to store |
| wr_asid_i | input | 8 | Tag to store |
| wr_vpn_i | input | 22 | Virtual page number to store |
| wr_ppn_i | input | 22 | Physical page number to store |
| wr_pg_i | input | 2 | Page-size code to store |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_hit_o | output | 1 | Single match |
| rsp_miss_o | output | 1 | No match |
| rsp_multi_o | output | 1 | Two or more matches |
| rsp_paddr_o | output | 32 | Physical address on a hit |

## Verification
The bench builds the block with its defaults: 64 slots and 8-bit tags. Every slot index can therefore be written, and the parallel compare is exercised at full width. In the random phase, page numbers are drawn from a small pool and mixed page sizes are used. This makes overlapping large pages, global entries and multiple matches happen often. Slots 0 and 63 are both reached, as are the remap boundary at exactly 0x1C000000 and the ordering of writes against lookups.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VA_W       = 32;
  localparam int unsigned PAGE_SHIFT = 10;
  localparam int unsigned VPN_W      = VA_W - PAGE_SHIFT;
  localparam int unsigned ASID_W     = 8;
  localparam int unsigned SQ_ALIGN   = 5;
  localparam logic [VA_W-1:0] REMAP_LIMIT = 32'h1C00_0000;
  localparam logic [VA_W-1:0] REMAP_BITS  = 32'hE000_0000;

  typedef enum logic [1:0] {
    PG_1K  = 2'd0,
    PG_4K  = 2'd1,
    PG_64K = 2'd2,
    PG_1M  = 2'd3
  } pg_size_e;

  typedef struct packed {
    logic              shr;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  ppn;
    pg_size_e          pg;
  } tlb_entry_t;

  function automatic logic [VPN_W-1:0] page_mask(pg_size_e pg);
    unique case (pg)
      PG_1K:   page_mask = {VPN_W{1'b1}};
      PG_4K:   page_mask = {{(VPN_W-2){1'b1}}, 2'b0};
      PG_64K:  page_mask = {{(VPN_W-6){1'b1}}, 6'b0};
      default: page_mask = {{(VPN_W-10){1'b1}}, 10'b0};
    endcase
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inv_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_vld_i,
  input  tlb_entry_t       wr_ent_i,
  output logic [ENTRIES-1:0] vld_o,
  output tlb_entry_t       ent_o [ENTRIES]
);
  logic [ENTRIES-1:0] vld_q;
  tlb_entry_t         ent_q [ENTRIES];
  logic               wr_go;

  // invalidate wins over a same-cycle write
  assign wr_go = wr_en_i && !inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    vld_q <= '0;
    else if (inv_i) vld_q <= '0;
    else if (wr_go) vld_q[wr_idx_i] <= wr_vld_i;
  end

  always_ff @(posedge clk_i) begin
    if (wr_go) ent_q[wr_idx_i] <= wr_ent_i;
  end

  assign vld_o = vld_q;
  assign ent_o = ent_q;

  assert_inv_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i |=> (vld_o == '0));

  assert_inv_beats_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_i && wr_en_i) |=> (vld_o == '0));

  assert_wr_lands_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_go |=> (vld_o[$past(wr_idx_i)] == $past(wr_vld_i)));
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 64
) (
  input  logic [ENTRIES-1:0] vld_i,
  input  tlb_entry_t         ent_i [ENTRIES],
  input  logic [VPN_W-1:0]   vpn_i,
  input  logic [ASID_W-1:0]  asid_i,
  input  logic               ign_asid_i,
  output logic [ENTRIES-1:0] hit_o
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [VPN_W-1:0] msk;
    logic             tag_ok;
    assign msk    = page_mask(ent_i[i].pg);
    assign tag_ok = ent_i[i].shr || ign_asid_i || (ent_i[i].asid == asid_i);
    assign hit_o[i] = vld_i[i] && tag_ok && (((ent_i[i].vpn ^ vpn_i) & msk) == '0);
  end
endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_vld_i,
  input  logic [VA_W-1:0]    va_i,
  input  logic               sq_i,
  input  logic [ENTRIES-1:0] hit_i,
  input  tlb_entry_t         ent_i [ENTRIES],
  output logic               hit_o,
  output logic               miss_o,
  output logic               multi_o,
  output logic [VA_W-1:0]    paddr_o
);
  logic [VPN_W-1:0] sel_ppn, sel_msk, vpn;
  logic [VA_W-1:0]  merged, adj;
  logic             any_hit, many_hit;

  assign vpn      = va_i[VA_W-1:PAGE_SHIFT];
  assign any_hit  = |hit_i;
  assign many_hit = |(hit_i & (hit_i - 1'b1));

  // AND-OR select; exact when a single entry hits
  always_comb begin
    sel_ppn = '0;
    sel_msk = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_i[i]) begin
        sel_ppn = sel_ppn | ent_i[i].ppn;
        sel_msk = sel_msk | page_mask(ent_i[i].pg);
      end
    end
  end

  assign merged = {(sel_ppn & sel_msk) | (vpn & ~sel_msk), va_i[PAGE_SHIFT-1:0]};

  always_comb begin
    if (sq_i)                     adj = {merged[VA_W-1:SQ_ALIGN], {SQ_ALIGN{1'b0}}};
    else if (merged > REMAP_LIMIT) adj = merged | REMAP_BITS;
    else                          adj = merged;
  end

  assign hit_o   = req_vld_i && any_hit && !many_hit;
  assign miss_o  = req_vld_i && !any_hit;
  assign multi_o = req_vld_i && many_hit;
  assign paddr_o = hit_o ? adj : '0;

  assert_multi_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_o |-> (!hit_o && paddr_o == '0));

  assert_sq_align_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && sq_i) |-> (paddr_o[SQ_ALIGN-1:0] == '0));

  assert_miss_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (paddr_o == '0));
endmodule

// File: rtl/tlb_xlate_top.sv
module tlb_xlate_top
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic [ASID_W-1:0] req_asid_i,
  input  logic              req_single_vm_i,
  input  logic              req_sq_i,
  input  logic              inv_all_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_vld_i,
  input  logic              wr_shr_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [VPN_W-1:0]  wr_ppn_i,
  input  logic [1:0]        wr_pg_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_miss_o,
  output logic              rsp_multi_o,
  output logic [VA_W-1:0]   rsp_paddr_o
);
  logic              rq_vld_q, rq_svm_q, rq_sq_q;
  logic [VA_W-1:0]   rq_va_q;
  logic [ASID_W-1:0] rq_asid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rq_vld_q  <= 1'b0;
      rq_svm_q  <= 1'b0;
      rq_sq_q   <= 1'b0;
      rq_va_q   <= '0;
      rq_asid_q <= '0;
    end else begin
      rq_vld_q <= req_valid_i;
      if (req_valid_i) begin
        rq_svm_q  <= req_single_vm_i;
        rq_sq_q   <= req_sq_i;
        rq_va_q   <= req_vaddr_i;
        rq_asid_q <= req_asid_i;
      end
    end
  end

  tlb_entry_t         wr_ent;
  tlb_entry_t         ents [ENTRIES];
  logic [ENTRIES-1:0] vld, hit_vec;

  assign wr_ent = '{shr: wr_shr_i, asid: wr_asid_i, vpn: wr_vpn_i,
                    ppn: wr_ppn_i, pg: pg_size_e'(wr_pg_i)};

  tlb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inv_i    (inv_all_i),
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .wr_vld_i (wr_vld_i),
    .wr_ent_i (wr_ent),
    .vld_o    (vld),
    .ent_o    (ents)
  );

  tlb_match #(.ENTRIES(ENTRIES)) u_match (
    .vld_i      (vld),
    .ent_i      (ents),
    .vpn_i      (rq_va_q[VA_W-1:PAGE_SHIFT]),
    .asid_i     (rq_asid_q),
    .ign_asid_i (rq_svm_q),
    .hit_o      (hit_vec)
  );

  tlb_resolve #(.ENTRIES(ENTRIES)) u_resolve (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_vld_i (rq_vld_q),
    .va_i      (rq_va_q),
    .sq_i      (rq_sq_q),
    .hit_i     (hit_vec),
    .ent_i     (ents),
    .hit_o     (rsp_hit_o),
    .miss_o    (rsp_miss_o),
    .multi_o   (rsp_multi_o),
    .paddr_o   (rsp_paddr_o)
  );

  assign rsp_valid_o = rq_vld_q;

  assert_rsp_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_rsp_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  assert_one_outcome_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($countones({rsp_hit_o, rsp_miss_o, rsp_multi_o}) == 1));

  assert_idle_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> ({rsp_hit_o, rsp_miss_o, rsp_multi_o} == 3'b0 && rsp_paddr_o == '0));
endmodule

// File: tb/tlb_xlate_top_tb.sv
`timescale 1ns/1ps
module tlb_xlate_top_tb;
  localparam int N = 64;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 0, req_single_vm_i = 0, req_sq_i = 0;
  logic [31:0] req_vaddr_i = '0;
  logic [7:0]  req_asid_i = '0;
  logic        inv_all_i = 0, wr_en_i = 0, wr_vld_i = 0, wr_shr_i = 0;
  logic [5:0]  wr_idx_i = '0;
  logic [7:0]  wr_asid_i = '0;
  logic [21:0] wr_vpn_i = '0, wr_ppn_i = '0;
  logic [1:0]  wr_pg_i = '0;
  logic        rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_multi_o;
  logic [31:0] rsp_paddr_o;

  always #2 clk_i = ~clk_i;

  tlb_xlate_top u_dut (.*);

  // reference state
  bit          m_vld [N];
  bit          m_shr [N];
  logic [7:0]  m_asid [N];
  logic [21:0] m_vpn [N], m_ppn [N];
  logic [1:0]  m_pg [N];
  bit          p_v, p_svm, p_sq;
  logic [31:0] p_va;
  logic [7:0]  p_asid;

  int    vectors = 0, fails = 0;
  string phase = "R1 reset";

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_v = 0;
      for (int i = 0; i < N; i++) m_vld[i] = 0;
    end else begin
      p_v = req_valid_i;
      if (req_valid_i) begin
        p_va = req_vaddr_i; p_asid = req_asid_i; p_svm = req_single_vm_i; p_sq = req_sq_i;
      end
      if (inv_all_i) begin
        for (int i = 0; i < N; i++) m_vld[i] = 0;
      end else if (wr_en_i) begin
        m_vld[wr_idx_i] = wr_vld_i; m_shr[wr_idx_i] = wr_shr_i;
        m_asid[wr_idx_i] = wr_asid_i; m_vpn[wr_idx_i] = wr_vpn_i;
        m_ppn[wr_idx_i] = wr_ppn_i; m_pg[wr_idx_i] = wr_pg_i;
      end
    end
  end

  function automatic logic [31:0] low_keep(logic [1:0] pg);
    int sh;
    sh = (pg == 0) ? 10 : (pg == 1) ? 12 : (pg == 2) ? 16 : 20;
    return (32'h1 << sh) - 1;
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni) begin
      logic        eh, em, ex;
      logic [31:0] ep, keep;
      int          n, sel;
      n = 0; sel = 0;
      eh = 0; em = 0; ex = 0; ep = '0;
      if (p_v) begin
        for (int i = 0; i < N; i++) begin
          keep = low_keep(m_pg[i]);
          if (m_vld[i] && (m_shr[i] || p_svm || m_asid[i] == p_asid) &&
              ((({m_vpn[i], 10'b0} ^ p_va) & ~keep) == 0)) begin
            n++; sel = i;
          end
        end
        if (n == 0) em = 1;
        else if (n > 1) ex = 1;
        else begin
          eh = 1;
          keep = low_keep(m_pg[sel]);
          ep = ({m_ppn[sel], 10'b0} & ~keep) | (p_va & keep);
          if (p_sq) ep = ep & ~32'h1F;
          else if (ep > 32'h1C00_0000) ep = ep | 32'hE000_0000;
        end
      end
      vectors++;
      if (rsp_valid_o !== p_v || rsp_hit_o !== eh || rsp_miss_o !== em ||
          rsp_multi_o !== ex || rsp_paddr_o !== ep) begin
        fails++;
        $display("FAIL %s: got v%0b h%0b m%0b x%0b pa=%h exp v%0b h%0b m%0b x%0b pa=%h",
                 phase, rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_multi_o, rsp_paddr_o,
                 p_v, eh, em, ex, ep);
      end
    end
  end

  task automatic clr();
    req_valid_i = 0; req_sq_i = 0; req_single_vm_i = 0; wr_en_i = 0; inv_all_i = 0;
  endtask

  task automatic wr(int idx, bit v, bit s, logic [7:0] a, logic [21:0] vpn,
                    logic [21:0] ppn, logic [1:0] pg);
    wr_idx_i = idx[5:0]; wr_vld_i = v; wr_shr_i = s; wr_asid_i = a;
    wr_vpn_i = vpn; wr_ppn_i = ppn; wr_pg_i = pg; wr_en_i = 1;
    @(negedge clk_i); clr();
  endtask

  task automatic look(logic [31:0] va, logic [7:0] a, bit svm, bit sq);
    req_vaddr_i = va; req_asid_i = a; req_single_vm_i = svm; req_sq_i = sq;
    req_valid_i = 1;
    @(negedge clk_i); clr();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    vectors++; // R1 reset state
    if (rsp_valid_o !== 0) begin
      fails++; $display("FAIL R1: got rsp_valid=%0b exp 0", rsp_valid_o);
    end
    rst_ni = 1;
    @(negedge clk_i);

    phase = "R1 empty miss";
    look(32'h1234_5678, 8'd0, 0, 0);
    look(32'hFFFF_FC00, 8'd3, 1, 0);
    @(negedge clk_i);

    phase = "R3 tag and global";
    wr(0, 1, 0, 8'd5, 22'h00ABC, 22'h00123, 2'd0);
    look({22'h00ABC, 10'h155}, 8'd5, 0, 0);
    look({22'h00ABC, 10'h155}, 8'd6, 0, 0);
    wr(1, 1, 1, 8'd9, 22'h00DEF, 22'h00456, 2'd0);
    look({22'h00DEF, 10'h001}, 8'd3, 0, 0);
    wr(2, 0, 1, 8'd0, 22'h00011, 22'h00022, 2'd0);
    look({22'h00011, 10'h000}, 8'd0, 0, 0);

    phase = "R4 R6 masked pages";
    wr(3, 1, 0, 8'd5, 22'h300000, 22'h155400, 2'd3);
    look({22'h3003FF, 10'h2AA}, 8'd5, 0, 0);
    look({22'h300400, 10'h2AA}, 8'd5, 0, 0);
    wr(63, 1, 0, 8'd5, 22'h0A0040, 22'h012345, 2'd2);
    look({22'h0A007F, 10'h3FF}, 8'd5, 0, 0);
    wr(8, 1, 0, 8'd5, 22'h0B0000, 22'h0000FF, 2'd1);
    look({22'h0B0003, 10'h010}, 8'd5, 0, 0);
    look({22'h0B0004, 10'h010}, 8'd5, 0, 0);

    phase = "R5 multi";
    wr(4, 1, 1, 8'd0, 22'h00ABC, 22'h00777, 2'd0);
    look({22'h00ABC, 10'h155}, 8'd5, 0, 0);
    look({22'h00ABC, 10'h155}, 8'd7, 0, 0);

    phase = "R8 single vm";
    wr(5, 1, 0, 8'd7, 22'h0F0F0, 22'h00999, 2'd0);
    look({22'h0F0F0, 10'h0AA}, 8'd1, 1, 0);
    look({22'h0F0F0, 10'h0AA}, 8'd1, 0, 0);

    phase = "R7 remap";
    wr(6, 1, 0, 8'd7, 22'h01000, 22'h070000, 2'd0);
    look({22'h01000, 10'h004}, 8'd7, 0, 0);
    look({22'h01000, 10'h000}, 8'd7, 0, 0);

    phase = "R12 sq align";
    look({22'h01000, 10'h01F}, 8'd7, 0, 1);
    look({22'h00DEF, 10'h15F}, 8'd7, 0, 1);

    phase = "R11 ordering";
    look({22'h01000, 10'h004}, 8'd7, 0, 0);
    wr(6, 0, 0, 8'd7, 22'h01000, 22'h070000, 2'd0); // during response: old entry seen
    look({22'h01000, 10'h004}, 8'd7, 0, 0);
    req_vaddr_i = {22'h02222, 10'h008}; req_asid_i = 8'd2; req_valid_i = 1;
    wr_idx_i = 6'd9; wr_vld_i = 1; wr_shr_i = 0; wr_asid_i = 8'd2;
    wr_vpn_i = 22'h02222; wr_ppn_i = 22'h03333; wr_pg_i = 2'd0; wr_en_i = 1;
    @(negedge clk_i); clr();

    phase = "R10 inv beats write";
    inv_all_i = 1; wr_en_i = 1; wr_idx_i = 6'd10; wr_vld_i = 1; wr_shr_i = 1;
    wr_vpn_i = 22'h04444; wr_ppn_i = 22'h0; wr_pg_i = 2'd0;
    @(negedge clk_i); clr();
    look({22'h04444, 10'h0}, 8'd0, 0, 0);

    phase = "R9 invalidate";
    wr(11, 1, 1, 8'd0, 22'h05555, 22'h00100, 2'd0);
    look({22'h05555, 10'h0}, 8'd0, 0, 0);
    inv_all_i = 1; @(negedge clk_i); clr();
    look({22'h05555, 10'h0}, 8'd0, 0, 0);
    look({22'h00ABC, 10'h155}, 8'd5, 0, 0);

    phase = "R2-random mix";
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      req_valid_i = ($urandom_range(0, 1) == 1);
      req_vaddr_i = {6'h0, 12'($urandom_range(0, 3) << 10), 4'($urandom_range(0, 15)),
                     10'($urandom)};
      req_asid_i = 8'($urandom_range(0, 3));
      req_single_vm_i = ($urandom_range(0, 7) == 0);
      req_sq_i = ($urandom_range(0, 7) == 0);
      wr_en_i = (r < 35);
      inv_all_i = (r == 99);
      wr_idx_i = 6'($urandom_range(0, N - 1));
      wr_vld_i = ($urandom_range(0, 3) != 0);
      wr_shr_i = ($urandom_range(0, 3) == 0);
      wr_asid_i = 8'($urandom_range(0, 3));
      wr_vpn_i = {6'h0, 12'($urandom_range(0, 3) << 10), 4'($urandom_range(0, 15))};
      wr_ppn_i = 22'($urandom);
      wr_pg_i = 2'($urandom_range(0, 3));
      @(negedge clk_i);
    end
    clr();
    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule